// File: doc/BRIEF.md
# Hot-Plug Slot Connection Sequencer

This block attaches one hot-plug expansion slot to a shared parallel bus and detaches it again. It owns five connection outputs: slot power enable, slot clock enable, the bus isolation switch enable, the 64-bit request enable and the slot reset. Software reaches it through a small byte-wide register port. In manual mode, software sets every output directly. In the two automatic modes, a single connect or disconnect command runs a timed sequence. The two automatic modes differ only in whether the isolation switches close before or after slot reset is released.

Two safety features sit beside the sequencer. The first is a protection override. When it is armed and either slot-detect input is high, it forces every connection output to its safe level at once, and it returns the sequencer to the disconnected idle state. The second is a bus-speed status bit, which follows the 66 MHz enable input while the bus reset input is low and holds it once that reset is released.

Register map (address `regAddr`, 5 bits):

- Configuration at any address whose low three bits are 0 (00h, 08h, 10h, 18h):
  - bits 7:4 are read-only and read `0001`.
  - bits 3:2 are the mode field.
  - bit 1 is the read-only speed bit.
  - bit 0 is the protection arm.
- Slot control at 01h:
  - bits 4:0 are the on-state of power, clock, switches, 64-bit request and run (reset released).
  - bit 5 reads busy.
  - bit 6 is write-only and requests a connect.
  - bit 7 is write-only and requests a disconnect.
- Step delay at 02h.

Top module: `slot_conn_seq`

## Requirements
- R1: After block reset the configuration register reads 10h, the control register reads 00h, and the outputs are safe: pwrEn=0, clkEnN=1, busSwEnN=1, req64En=0, slotRstN=0.
- R2: The configuration register reads the same at 00h, 08h, 10h and 18h. Writes to bits 7:4 and bit 1 have no effect. Bits 3:2 and bit 0 read back what was written.
- R3: The speed bit (configuration bit 1) takes the m66En value while busRstN is low and holds its value while busRstN is high.
- R4: In manual mode (mode field 00), a control write sets the outputs from bits 4:0. Bit 0 sets pwrEn=1, bit 1 sets clkEnN=0, bit 2 sets busSwEnN=0, bit 3 sets req64En=1 and bit 4 sets slotRstN=1. The control register reads these bits back in bits 4:0, with busy in bit 5.
- R5: Mode code 11 behaves exactly as manual mode.
- R6: In mode 01, a connect request asserts power at the accepting edge, then waits for pwrGood. D cycles after pwrGood is sampled high, the clock is enabled. D cycles later the switches and 64-bit request are enabled. D cycles after that, slot reset is released.
- R7: In mode 10 the connect order is power, clock, reset release and then switches with 64-bit request, with the same D-cycle spacing.
- R8: The step spacing D equals 16 plus the value of the delay register at 02h.
- R9: A disconnect request in the connected state asserts slot reset at the accepting edge. It then removes the switches with 64-bit request, then the clock and then the power, each D cycles after the previous step.
- R10: Control bit 5 (busy) is 1 while a sequence runs. Connect and disconnect requests made while busy are ignored, and so are writes to the mode field.
- R11: With protection armed (bit 0 = 1) and either detect input high, the outputs go to safe levels in the same cycle and the on-state clears. The outputs stay safe after detect falls, and a new connect then starts from the disconnected state.
- R12: In an automatic mode, control writes to bits 4:0 are ignored. In manual mode, connect and disconnect bits start no sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Block reset, active low, asynchronous |
| regAddr | input | 5 | Register address |
| regWrEn | input | 1 | Register write strobe for one cycle |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data, combinational from regAddr |
| detect | input | 2 | Slot-detect inputs for protection |
| pwrGood | input | 1 | Slot power is stable |
| m66En | input | 1 | Bus 66 MHz enable input |
| busRstN | input | 1 | Bus reset input, active low |
| pwrEn | output | 1 | Slot power enable, active high |
| clkEnN | output | 1 | Slot clock enable, active low |
| busSwEnN | output | 1 | Bus isolation switch enable, active low |
| req64En | output | 1 | 64-bit request enable, active high |
| slotRstN | output | 1 | Slot reset, active low |

## Verification
The assertions assume three things about the inputs:

- pwrGood stays low until power has been requested.
- The mode field is changed only while the sequencer is idle, because a write during a sequence is blocked.
- A mode switch does not land between an automatic step and its own check.

The stimulus drives every input on the falling clock edge and issues mode changes only from the idle states. It holds detect low except in the protection tests, so the ordering properties see only edges made by the sequencer.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 5;
  localparam int ON_W   = 5;

  localparam int ON_PWR = 0;
  localparam int ON_CLK = 1;
  localparam int ON_SW  = 2;
  localparam int ON_R64 = 3;
  localparam int ON_RUN = 4;

  localparam logic [ADDR_W-1:0] ADDR_CTL = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_DLY = 5'h02;
  localparam logic [3:0]        REV_CODE = 4'b0001;

  localparam logic [1:0] MODE_SW_FIRST  = 2'b01;
  localparam logic [1:0] MODE_RST_FIRST = 2'b10;

  typedef enum logic [3:0] {
    ST_OFF, ST_C_PWR, ST_C_CLK, ST_C_FIRST, ST_C_SECOND,
    ST_ON, ST_D_SW, ST_D_CLK, ST_D_PWR
  } seqState_t;

  typedef struct packed {
    logic [ON_W-1:0] onSet;
    logic [ON_W-1:0] onClr;
    logic            loadTimer;
    logic            clearAll;
  } seqStrobe_t;

endpackage

// File: rtl/slot_seq_ctrl.sv
module slot_seq_ctrl
  import slot_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       isAuto,
  input  logic       swFirst,
  input  logic       connReq,
  input  logic       discReq,
  input  logic       pwrGood,
  input  logic       timerDone,
  input  logic       protActive,
  output seqStrobe_t strobe,
  output logic       busy
);

  seqState_t state, nxtState;

  localparam logic [ON_W-1:0] SW_GROUP = ON_W'((1 << ON_SW) | (1 << ON_R64));
  localparam logic [ON_W-1:0] RUN_BIT  = ON_W'(1 << ON_RUN);

  always_comb begin
    strobe   = '0;
    nxtState = state;
    unique case (state)
      ST_OFF: if (isAuto && connReq) begin
        strobe.onSet[ON_PWR] = 1'b1;
        nxtState = ST_C_PWR;
      end
      ST_C_PWR: if (pwrGood) begin
        strobe.loadTimer = 1'b1;
        nxtState = ST_C_CLK;
      end
      ST_C_CLK: if (timerDone) begin
        strobe.onSet[ON_CLK] = 1'b1;
        strobe.loadTimer = 1'b1;
        nxtState = ST_C_FIRST;
      end
      ST_C_FIRST: if (timerDone) begin
        strobe.onSet = swFirst ? SW_GROUP : RUN_BIT;
        strobe.loadTimer = 1'b1;
        nxtState = ST_C_SECOND;
      end
      ST_C_SECOND: if (timerDone) begin
        strobe.onSet = swFirst ? RUN_BIT : SW_GROUP;
        nxtState = ST_ON;
      end
      ST_ON: if (isAuto && discReq) begin
        strobe.onClr = RUN_BIT;
        strobe.loadTimer = 1'b1;
        nxtState = ST_D_SW;
      end
      ST_D_SW: if (timerDone) begin
        strobe.onClr = SW_GROUP;
        strobe.loadTimer = 1'b1;
        nxtState = ST_D_CLK;
      end
      ST_D_CLK: if (timerDone) begin
        strobe.onClr[ON_CLK] = 1'b1;
        strobe.loadTimer = 1'b1;
        nxtState = ST_D_PWR;
      end
      ST_D_PWR: if (timerDone) begin
        strobe.onClr[ON_PWR] = 1'b1;
        nxtState = ST_OFF;
      end
      default: nxtState = ST_OFF;
    endcase
    if (protActive) begin
      strobe          = '0;
      strobe.clearAll = 1'b1;
      nxtState        = ST_OFF;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nxtState;
  end

  assign busy = (state != ST_OFF) && (state != ST_ON);

  AST_PROT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    protActive |=> (state == ST_OFF)); // R11

  AST_WAIT_PGOOD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_C_PWR && !pwrGood && !protActive) |=> (state == ST_C_PWR)); // R6

  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_C_PWR && !pwrGood && !protActive && discReq) |=> busy); // R10

endmodule

// File: rtl/slot_seq_dp.sv
module slot_seq_dp
  import slot_seq_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int MIN_GAP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [1:0]        detect,
  input  logic              m66En,
  input  logic              busRstN,
  input  seqStrobe_t        strobe,
  input  logic              busy,
  output logic              isAuto,
  output logic              swFirst,
  output logic              connReq,
  output logic              discReq,
  output logic              timerDone,
  output logic              protActive,
  output logic              pwrEn,
  output logic              clkEnN,
  output logic              busSwEnN,
  output logic              req64En,
  output logic              slotRstN
);

  localparam int TMR_W = $clog2(MIN_GAP + (1 << DLY_W));

  logic [1:0]       seqMode;
  logic             protEn;
  logic             speedBit;
  logic [DLY_W-1:0] dlyReg;
  logic [ON_W-1:0]  onBits;
  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] gapLoad;
  logic             cfgHit, ctlHit, dlyHit;

  assign cfgHit = (regAddr[2:0] == 3'd0);
  assign ctlHit = (regAddr == ADDR_CTL);
  assign dlyHit = (regAddr == ADDR_DLY);

  assign isAuto     = (seqMode == MODE_SW_FIRST) || (seqMode == MODE_RST_FIRST);
  assign swFirst    = (seqMode == MODE_SW_FIRST);
  assign connReq    = regWrEn && ctlHit && regWrData[6];
  assign discReq    = regWrEn && ctlHit && regWrData[7];
  assign protActive = protEn && (|detect);
  assign gapLoad    = TMR_W'(MIN_GAP) + TMR_W'(dlyReg) - TMR_W'(1);
  assign timerDone  = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqMode <= 2'b00;
      protEn  <= 1'b0;
      dlyReg  <= '0;
    end else if (regWrEn) begin
      if (cfgHit) begin
        protEn <= regWrData[0];
        if (!busy) seqMode <= regWrData[3:2];
      end
      if (dlyHit) dlyReg <= regWrData[DLY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         speedBit <= 1'b0;
    else if (!busRstN) speedBit <= m66En;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              onBits <= '0;
    else if (strobe.clearAll)               onBits <= '0;
    else if (regWrEn && ctlHit && !isAuto)  onBits <= regWrData[ON_W-1:0];
    else onBits <= (onBits & ~strobe.onClr) | strobe.onSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= '0;
    else if (strobe.loadTimer) timer <= gapLoad;
    else if (!timerDone)       timer <= timer - TMR_W'(1);
  end

  always_comb begin
    regRdData = '0;
    if (cfgHit)      regRdData = {REV_CODE, seqMode, speedBit, protEn};
    else if (ctlHit) regRdData = REG_W'({busy, onBits});
    else if (dlyHit) regRdData = REG_W'(dlyReg);
  end

  assign pwrEn    =   onBits[ON_PWR] && !protActive;
  assign clkEnN   = !(onBits[ON_CLK] && !protActive);
  assign busSwEnN = !(onBits[ON_SW]  && !protActive);
  assign req64En  =   onBits[ON_R64] && !protActive;
  assign slotRstN =   onBits[ON_RUN] && !protActive;

  AST_PROT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    protActive |=> (onBits == '0)); // R11

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) |-> $stable(seqMode)); // R10

  AST_SPEED_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(busRstN) |-> $stable(speedBit)); // R3

  AST_CLK_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rstN)
    (isAuto && $rose(onBits[ON_CLK])) |-> onBits[ON_PWR]); // R6

  AST_SW_BEFORE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (isAuto && swFirst && $rose(onBits[ON_RUN])) |-> onBits[ON_SW]); // R6

  AST_RUN_BEFORE_SW: assert property (@(posedge clk) disable iff (!rstN)
    (isAuto && !swFirst && $rose(onBits[ON_SW])) |-> onBits[ON_RUN]); // R7

endmodule

// File: rtl/slot_conn_seq.sv
module slot_conn_seq
  import slot_seq_pkg::*;
#(
  parameter int DLY_W   = 8,
  parameter int MIN_GAP = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  input  logic [1:0]        detect,
  input  logic              pwrGood,
  input  logic              m66En,
  input  logic              busRstN,
  output logic              pwrEn,
  output logic              clkEnN,
  output logic              busSwEnN,
  output logic              req64En,
  output logic              slotRstN
);

  seqStrobe_t strobe;
  logic busy, isAuto, swFirst, connReq, discReq, timerDone, protActive;

  slot_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .isAuto     (isAuto),
    .swFirst    (swFirst),
    .connReq    (connReq),
    .discReq    (discReq),
    .pwrGood    (pwrGood),
    .timerDone  (timerDone),
    .protActive (protActive),
    .strobe     (strobe),
    .busy       (busy)
  );

  slot_seq_dp #(.DLY_W(DLY_W), .MIN_GAP(MIN_GAP)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .detect     (detect),
    .m66En      (m66En),
    .busRstN    (busRstN),
    .strobe     (strobe),
    .busy       (busy),
    .isAuto     (isAuto),
    .swFirst    (swFirst),
    .connReq    (connReq),
    .discReq    (discReq),
    .timerDone  (timerDone),
    .protActive (protActive),
    .pwrEn      (pwrEn),
    .clkEnN     (clkEnN),
    .busSwEnN   (busSwEnN),
    .req64En    (req64En),
    .slotRstN   (slotRstN)
  );

endmodule

// File: tb/slot_conn_seq_bench.sv
module slot_conn_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_MAN = 6;
  // {control write data, expected {pwrEn, clkEnN, busSwEnN, req64En, slotRstN}}
  localparam logic [12:0] MAN_VEC [N_MAN] = '{
    {8'h01, 5'b11100}, {8'h03, 5'b10100}, {8'h07, 5'b10000},
    {8'h0F, 5'b10010}, {8'h1F, 5'b10011}, {8'h00, 5'b01100}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] detect = 2'b00;
  logic       pwrGood = 1'b0;
  logic       m66En = 1'b0;
  logic       busRstN = 1'b0;
  logic       pwrEn, clkEnN, busSwEnN, req64En, slotRstN;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_conn_seq u_slot_conn_seq (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .detect(detect),
    .pwrGood(pwrGood), .m66En(m66En), .busRstN(busRstN), .pwrEn(pwrEn),
    .clkEnN(clkEnN), .busSwEnN(busSwEnN), .req64En(req64En), .slotRstN(slotRstN)
  );

  function automatic logic [4:0] outVec();
    return {pwrEn, clkEnN, busSwEnN, req64En, slotRstN};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sample one output step: unchanged after n-1 cycles, new value one cycle later.
  task automatic step(input string req, input int n, input logic [4:0] oldV, input logic [4:0] newV);
    waitN(n - 1);
    chk({req, " before step"}, 32'(outVec()), 32'(oldV));
    waitN(1);
    chk({req, " at step"}, 32'(outVec()), 32'(newV));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int dGap;
    waitN(3);
    chk("R1 outputs in reset", 32'(outVec()), 32'h0C);
    rstN = 1'b1;
    waitN(1);
    rd(5'h00, d); chk("R1 config after reset", 32'(d), 32'h10);
    rd(5'h01, d); chk("R1 control after reset", 32'(d), 32'h00);
    chk("R1 outputs after reset", 32'(outVec()), 32'h0C);
    rd(5'h08, d); chk("R2 alias 08h", 32'(d), 32'h10);
    rd(5'h10, d); chk("R2 alias 10h", 32'(d), 32'h10);
    rd(5'h18, d); chk("R2 alias 18h", 32'(d), 32'h10);

    // R3 speed latch
    m66En = 1'b1; waitN(2);
    rd(5'h00, d); chk("R3 speed follows during bus reset", 32'(d), 32'h12);
    busRstN = 1'b1; m66En = 1'b0; waitN(2);
    rd(5'h00, d); chk("R3 speed holds after bus reset", 32'(d), 32'h12);
    busRstN = 1'b0; waitN(2);
    rd(5'h00, d); chk("R3 speed relatches", 32'(d), 32'h10);
    busRstN = 1'b1;

    // R2 read-only bits
    waitN(1);
    wr(5'h00, 8'hF3);
    rd(5'h18, d); chk("R2 read-only bits kept", 32'(d), 32'h11);
    wr(5'h00, 8'h00);

    // R4 manual table
    for (int i = 0; i < N_MAN; i++) begin
      wr(5'h01, MAN_VEC[i][12:5]);
      chk("R4 manual outputs", 32'(outVec()), 32'(MAN_VEC[i][4:0]));
      rd(5'h01, d); chk("R4 manual readback", 32'(d), 32'(MAN_VEC[i][9:5]));
    end

    // R12 manual ignores requests
    wr(5'h01, 8'h41); waitN(5);
    rd(5'h01, d); chk("R12 manual connect ignored", 32'(d), 32'h01);
    wr(5'h01, 8'h00);

    // R5 reserved mode acts manual
    wr(5'h00, 8'h0C);
    rd(5'h00, d); chk("R5 mode 11 stored", 32'(d), 32'h1C);
    wr(5'h01, 8'h1F);
    chk("R5 mode 11 manual outputs", 32'(outVec()), 32'h13);
    wr(5'h01, 8'h40); waitN(3);
    rd(5'h01, d); chk("R5 mode 11 no sequence", 32'(d), 32'h00);
    wr(5'h00, 8'h00);

    // R6 / R8 mode 01 connect, D = 16 + 4
    dGap = 20;
    wr(5'h02, 8'h04);
    rd(5'h02, d); chk("R8 delay readback", 32'(d), 32'h04);
    wr(5'h00, 8'h04);
    wr(5'h01, 8'h40);
    chk("R6 power at accept", 32'(outVec()), 32'h1C);
    rd(5'h01, d); chk("R10 busy while connecting", 32'(d), 32'h21);
    wr(5'h01, 8'h9F);
    wr(5'h00, 8'h00);
    rd(5'h00, d); chk("R10 mode write ignored when busy", 32'(d), 32'h14);
    rd(5'h01, d); chk("R10 disconnect and bits ignored when busy", 32'(d), 32'h21);
    waitN(10);
    chk("R6 waits for pwrGood", 32'(outVec()), 32'h1C);
    pwrGood = 1'b1;
    step("R8 R6 clock", dGap + 1, 5'b11100, 5'b10100);
    step("R8 R6 switches", dGap, 5'b10100, 5'b10010);
    step("R6 reset release", dGap, 5'b10010, 5'b10011);
    rd(5'h01, d); chk("R6 connected idle", 32'(d), 32'h1F);

    // R12 auto mode ignores manual bits
    wr(5'h01, 8'h00);
    chk("R12 auto ignores manual bits", 32'(outVec()), 32'h13);

    // R9 disconnect
    wr(5'h01, 8'h80);
    chk("R9 reset asserted first", 32'(outVec()), 32'h12);
    step("R9 switches off", dGap, 5'b10010, 5'b10100);
    step("R9 clock off", dGap, 5'b10100, 5'b11100);
    step("R9 power off", dGap, 5'b11100, 5'b01100);
    rd(5'h01, d); chk("R9 disconnected idle", 32'(d), 32'h00);

    // R7 / R8 mode 10, D = 16 (pwrGood already high)
    dGap = 16;
    wr(5'h02, 8'h00);
    wr(5'h00, 8'h08);
    wr(5'h01, 8'h40);
    chk("R7 power at accept", 32'(outVec()), 32'h1C);
    step("R8 R7 clock", dGap + 1, 5'b11100, 5'b10100);
    step("R7 reset release first", dGap, 5'b10100, 5'b10101);
    step("R7 switches last", dGap, 5'b10101, 5'b10011);

    // R11 protection
    wr(5'h00, 8'h09);
    chk("R11 armed no detect", 32'(outVec()), 32'h13);
    detect = 2'b10; #1;
    chk("R11 override same cycle", 32'(outVec()), 32'h0C);
    waitN(2); detect = 2'b00; waitN(2);
    chk("R11 stays safe", 32'(outVec()), 32'h0C);
    rd(5'h01, d); chk("R11 state cleared", 32'(d), 32'h00);
    wr(5'h01, 8'h40);
    chk("R11 reconnect from idle", 32'(outVec()), 32'h1C);
    waitN(3);
    detect = 2'b01; waitN(2);
    rd(5'h01, d); chk("R11 override aborts sequence", 32'(d), 32'h00);
    chk("R11 outputs safe during sequence", 32'(outVec()), 32'h0C);
    detect = 2'b00;
    waitN(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule